// File: doc/BRIEF.md
# Vector Extension Prefix Field Extractor

This block sits in an instruction byte-stream decoder. When an opcode byte of 8'hC4 or 8'hC5 is presented together with a start pulse, it decides whether that byte opens a vector extension prefix or is an ordinary opcode. If it opens a prefix, the block captures the one or two payload bytes that follow and decodes them. The decoded fields are:

- a four-bit lookup index for the opcode map;
- an effective set of register-extension bits (W, R, X, B);
- the vector length bit;
- the W bit;
- the register number of the extra source operand.

Outside 64-bit mode, the block inspects the two top bits of the byte after the opcode before consuming it. If they are not 11, the opcode is an ordinary instruction and the byte is left in the stream for the rest of the decoder.

The result is signalled by `done`. All fields stay stable until the next start. A separate combinational path decodes a register number held in the upper nibble of a trailing immediate byte. The end-of-input indication and reserved map values both raise an error flag. A start pulse is accepted in any state and restarts the capture.

Top module: `vxp_prefix_extract`

## Requirements
- R1: After reset, `busy`, `done`, `take`, `is_vec` and `err` are low, and every decoded field output is zero.
- R2: A start whose `op_byte` is neither 8'hC4 nor 8'hC5 gives `done` high with `is_vec` low on the next cycle. No payload byte is taken.
- R3: Outside 64-bit mode (`mode64` low when start is sampled), the first byte after the opcode is examined. If its bits 7:6 are not 2'b11, `take` stays low while it is presented, and the block finishes with `is_vec` low and `err` low. In 64-bit mode these bits are not examined.
- R4: An 8'hC4 prefix consumes exactly two payload bytes and 8'hC5 exactly one. `take` is high, combinationally, in each cycle a payload byte is accepted.
- R5: `map_idx` is {second byte[1:0], first byte[1:0]} for 8'hC4 and {payload[1:0], 2'b01} for 8'hC5. For 8'hC4, a first-byte value in bits 4:0 of 0 or above 3 raises `err` while `is_vec` is still high.
- R6: `ext_eff` has W in bit 3, R in bit 2, X in bit 1 and B in bit 0. R, X and B are the inverses of first-byte bits 7, 6 and 5. For 8'hC5, X, B and W are zero. The result is ANDed with `ext_allow` captured at start. `ext_eff` is zero outside 64-bit mode.
- R7: `w_bit` is bit 7 of the second 8'hC4 byte and is not masked. It is always 0 for 8'hC5.
- R8: `vec_l` is bit 2 of the last payload byte. `vreg` is the bitwise inverse of bits 6:3 of the last payload byte.
- R9: `imm_reg` is `imm_byte[7:4]` when `mode64` is high, and {1'b0, `imm_byte[6:4]`} otherwise.
- R10: `end_of_input` while a payload byte is awaited ends the capture with `err` high and `is_vec` low. It wins over a byte presented in the same cycle, which is then not taken.
- R11: While `done` is high and no start arrives, every decoded field holds its value.
- R12: While `byte_valid` is low in a payload state, the block waits with `busy` high and `done` low.
- R13: When `is_vec` is low, `map_idx`, `ext_eff`, `vec_l`, `w_bit` and `vreg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opcode byte present; starts or restarts a capture |
| op_byte | input | 8 | Opcode byte, sampled with start |
| mode64 | input | 1 | 64-bit mode; captured at start, used live for imm_reg |
| ext_allow | input | 4 | Allowed extension bits {W,R,X,B}, captured at start |
| byte_valid | input | 1 | A stream byte is offered on byte_in |
| byte_in | input | 8 | Next stream byte |
| end_of_input | input | 1 | Stream exhausted |
| imm_byte | input | 8 | Trailing immediate byte for register decode |
| take | output | 1 | The offered byte is consumed this cycle |
| busy | output | 1 | Awaiting a payload byte |
| done | output | 1 | Result valid and held |
| is_vec | output | 1 | A prefix was recognised |
| err | output | 1 | Reserved map or early end of input |
| map_idx | output | 4 | Map lookup index |
| ext_eff | output | 4 | Effective extension bits {W,R,X,B} |
| vec_l | output | 1 | Vector length bit |
| w_bit | output | 1 | Unmasked W bit |
| vreg | output | 4 | Extra source register number |
| imm_reg | output | 4 | Register number from the immediate |

## Verification
Two things can meet in one cycle: the end-of-input signal and an offered payload byte. The bench provokes this by capturing the first 8'hC4 byte and then raising `byte_valid` and `end_of_input` together. It judges that `take` stays low in that cycle and that the result shows `err` high with `is_vec` low. A second collision is a new start arriving while a payload byte is awaited. The bench checks that the fresh capture fully replaces the abandoned one.

// File: rtl/vxp_pkg.sv
package vxp_pkg;
   localparam int VXP_BYTE_W = 8;
   localparam int VXP_IDX_W  = 4;
   localparam int VXP_REG_W  = 4;
   localparam int VXP_EXT_W  = 4;
   localparam logic [7:0] VXP_OP_LONG  = 8'hC4;
   localparam logic [7:0] VXP_OP_SHORT = 8'hC5;
   localparam logic [4:0] VXP_MAP_MAX  = 5'd3;

   typedef enum logic [1:0] {ST_IDLE, ST_PAY1, ST_PAY2, ST_DONE} vxp_state_e;

   typedef struct packed {
      logic [VXP_IDX_W-1:0] idx;
      logic [VXP_EXT_W-1:0] ext;
      logic                 vl;
      logic                 w;
      logic [VXP_REG_W-1:0] vreg;
   } vxp_fields_t;
endpackage

// File: rtl/vxp_capture.sv
module vxp_capture
   import vxp_pkg::*;
#(
   parameter int BYTE_W = VXP_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] op_byte,
   input  logic              mode64,
   input  logic [3:0]        ext_allow,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              end_of_input,
   output logic              take,
   output logic              busy,
   output logic              done,
   output logic              vec_ok,
   output logic              err,
   output logic              long_q,
   output logic              m64_q,
   output logic [3:0]        mask_q,
   output logic [BYTE_W-1:0] b1_q,
   output logic [BYTE_W-1:0] b2_q
);
   localparam int TOP = BYTE_W - 1;

   vxp_state_e state;
   logic       mod_ok;
   logic       map_bad;

   assign mod_ok  = m64_q || (byte_in[TOP:TOP-1] == 2'b11);
   assign map_bad = (b1_q[4:0] == 5'd0) || (b1_q[4:0] > VXP_MAP_MAX);
   assign busy    = (state == ST_PAY1) || (state == ST_PAY2);
   assign done    = (state == ST_DONE);

   always_comb begin
      take = 1'b0;
      if (byte_valid && !end_of_input) begin
         if (state == ST_PAY1)      take = mod_ok;
         else if (state == ST_PAY2) take = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         long_q <= 1'b0;
         m64_q  <= 1'b0;
         mask_q <= '0;
         b1_q   <= '0;
         b2_q   <= '0;
         vec_ok <= 1'b0;
         err    <= 1'b0;
      end else if (start) begin
         long_q <= (op_byte == VXP_OP_LONG);
         m64_q  <= mode64;
         mask_q <= ext_allow;
         b1_q   <= '0;
         b2_q   <= '0;
         vec_ok <= 1'b0;
         err    <= 1'b0;
         state  <= (op_byte == VXP_OP_LONG || op_byte == VXP_OP_SHORT) ? ST_PAY1 : ST_DONE;
      end else begin
         case (state)
            ST_PAY1: begin
               if (end_of_input) begin
                  state <= ST_DONE;
                  err   <= 1'b1;
               end else if (byte_valid) begin
                  if (!mod_ok) begin
                     state <= ST_DONE;
                  end else begin
                     b1_q <= byte_in;
                     if (long_q) begin
                        state <= ST_PAY2;
                     end else begin
                        state  <= ST_DONE;
                        vec_ok <= 1'b1;
                     end
                  end
               end
            end
            ST_PAY2: begin
               if (end_of_input) begin
                  state <= ST_DONE;
                  err   <= 1'b1;
               end else if (byte_valid) begin
                  b2_q   <= byte_in;
                  vec_ok <= 1'b1;
                  err    <= map_bad;
                  state  <= ST_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   // R10
   eoi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && end_of_input && !start) |=> (done && err && !vec_ok));

   // R3
   legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PAY1) && byte_valid && !end_of_input && !start && !m64_q &&
       (byte_in[TOP:TOP-1] != 2'b11)) |=> (done && !vec_ok && !err));

   // R4
   short_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PAY1) && take && !long_q && !start) |=> (done && vec_ok));
endmodule

// File: rtl/vxp_fields.sv
module vxp_fields
   import vxp_pkg::*;
#(
   parameter int BYTE_W = VXP_BYTE_W
) (
   input  logic              long_q,
   input  logic              m64_q,
   input  logic [3:0]        mask_q,
   input  logic              vec_ok,
   input  logic [BYTE_W-1:0] b1_q,
   input  logic [BYTE_W-1:0] b2_q,
   output vxp_fields_t       f
);
   logic [BYTE_W-1:0] last_b;
   logic [3:0]        ext_raw;

   assign last_b = long_q ? b2_q : b1_q;

   always_comb begin
      if (long_q) ext_raw = {b2_q[7], ~b1_q[7], ~b1_q[6], ~b1_q[5]};
      else        ext_raw = {1'b0, ~b1_q[7], 2'b00};
      f = '0;
      if (vec_ok) begin
         f.idx  = long_q ? {b2_q[1:0], b1_q[1:0]} : {b1_q[1:0], 2'b01};
         f.ext  = m64_q ? (ext_raw & mask_q) : '0;
         f.vl   = last_b[2];
         f.w    = long_q & b2_q[7];
         f.vreg = ~last_b[6:3];
      end
   end
endmodule

// File: rtl/vxp_imm_reg.sv
module vxp_imm_reg
   import vxp_pkg::*;
#(
   parameter int BYTE_W = VXP_BYTE_W,
   parameter int REG_W  = VXP_REG_W
) (
   input  logic              mode64,
   input  logic [BYTE_W-1:0] imm_byte,
   output logic [REG_W-1:0]  imm_reg
);
   localparam int HI = BYTE_W - 1;
   localparam int LO = BYTE_W - REG_W;

   assign imm_reg = mode64 ? imm_byte[HI:LO] : {1'b0, imm_byte[HI-1:LO]};
endmodule

// File: rtl/vxp_prefix_extract.sv
module vxp_prefix_extract
   import vxp_pkg::*;
#(
   parameter int BYTE_W   = VXP_BYTE_W,
   parameter int REG_W    = VXP_REG_W,
   parameter bit IMM_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] op_byte,
   input  logic              mode64,
   input  logic [3:0]        ext_allow,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              end_of_input,
   input  logic [BYTE_W-1:0] imm_byte,
   output logic              take,
   output logic              busy,
   output logic              done,
   output logic              is_vec,
   output logic              err,
   output logic [3:0]        map_idx,
   output logic [3:0]        ext_eff,
   output logic              vec_l,
   output logic              w_bit,
   output logic [REG_W-1:0]  vreg,
   output logic [REG_W-1:0]  imm_reg
);
   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("vxp_prefix_extract: BYTE_W must be 8");
      end
      if (REG_W != VXP_REG_W) begin : g_bad_reg
         $error("vxp_prefix_extract: REG_W must match the package register width");
      end
   endgenerate

   logic              long_q, m64_q;
   logic [3:0]        mask_q;
   logic [BYTE_W-1:0] b1_q, b2_q;
   vxp_fields_t       fl;
   logic [REG_W-1:0]  imm_d;

   vxp_capture #(.BYTE_W(BYTE_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .start(start), .op_byte(op_byte), .mode64(mode64),
      .ext_allow(ext_allow), .byte_valid(byte_valid), .byte_in(byte_in),
      .end_of_input(end_of_input), .take(take), .busy(busy), .done(done),
      .vec_ok(is_vec), .err(err), .long_q(long_q), .m64_q(m64_q), .mask_q(mask_q),
      .b1_q(b1_q), .b2_q(b2_q));

   vxp_fields #(.BYTE_W(BYTE_W)) u_fld (
      .long_q(long_q), .m64_q(m64_q), .mask_q(mask_q), .vec_ok(is_vec),
      .b1_q(b1_q), .b2_q(b2_q), .f(fl));

   vxp_imm_reg #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_imm (
      .mode64(mode64), .imm_byte(imm_byte), .imm_reg(imm_d));

   generate
      if (IMM_PIPE) begin : g_imm_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) imm_reg <= '0;
            else        imm_reg <= imm_d;
         end
      end else begin : g_imm_comb
         assign imm_reg = imm_d;
      end
   endgenerate

   assign map_idx = fl.idx;
   assign ext_eff = fl.ext;
   assign vec_l   = fl.vl;
   assign w_bit   = fl.w;
   assign vreg    = fl.vreg;

   // R11
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable({map_idx, ext_eff, vec_l, w_bit, vreg, is_vec, err}));

   // R7
   short_w_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_vec && !long_q) |-> (!w_bit && !ext_eff[3]));

   // R6
   narrow_ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !m64_q) |-> (ext_eff == 4'h0));
endmodule

// File: tb/tb_vxp_prefix_extract.sv
`timescale 1ns/1ps
module tb_vxp_prefix_extract;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] op_byte = '0;
   logic       mode64 = 1'b0;
   logic [3:0] ext_allow = '0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_in = '0;
   logic       end_of_input = 1'b0;
   logic [7:0] imm_byte = '0;
   logic       take, busy, done, is_vec, err, vec_l, w_bit;
   logic [3:0] map_idx, ext_eff, vreg, imm_reg;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   vxp_prefix_extract dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_byte(op_byte), .mode64(mode64),
      .ext_allow(ext_allow), .byte_valid(byte_valid), .byte_in(byte_in),
      .end_of_input(end_of_input), .imm_byte(imm_byte), .take(take), .busy(busy),
      .done(done), .is_vec(is_vec), .err(err), .map_idx(map_idx), .ext_eff(ext_eff),
      .vec_l(vec_l), .w_bit(w_bit), .vreg(vreg), .imm_reg(imm_reg));

   typedef struct packed {
      logic       m64;
      logic [7:0] op;
      logic [7:0] b1;
      logic [7:0] b2;
      logic [3:0] mask;
      logic       vec;
      logic       er;
      logic [3:0] idx;
      logic [3:0] ext;
      logic       l;
      logic       w;
      logic [3:0] vr;
      logic [1:0] nt;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'hC5, 8'hF8, 8'h00, 4'hF, 1'b1, 1'b0, 4'h1, 4'h0, 1'b0, 1'b0, 4'h0, 2'd1},
      '{1'b1, 8'hC5, 8'h45, 8'h00, 4'hF, 1'b1, 1'b0, 4'h5, 4'h4, 1'b1, 1'b0, 4'h7, 2'd1},
      '{1'b1, 8'hC4, 8'h02, 8'hFD, 4'hF, 1'b1, 1'b0, 4'h6, 4'hF, 1'b1, 1'b1, 4'h0, 2'd2},
      '{1'b1, 8'hC4, 8'h02, 8'hFD, 4'h5, 1'b1, 1'b0, 4'h6, 4'h5, 1'b1, 1'b1, 4'h0, 2'd2},
      '{1'b1, 8'hC4, 8'hA3, 8'h3A, 4'hF, 1'b1, 1'b0, 4'hB, 4'h2, 1'b0, 1'b0, 4'h8, 2'd2},
      '{1'b1, 8'hC4, 8'hE0, 8'h00, 4'hF, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 4'hF, 2'd2},
      '{1'b1, 8'hC4, 8'hE4, 8'h87, 4'hF, 1'b1, 1'b1, 4'hC, 4'h8, 1'b1, 1'b1, 4'hF, 2'd2},
      '{1'b0, 8'hC4, 8'h80, 8'h00, 4'hF, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 2'd0},
      '{1'b0, 8'hC5, 8'hC1, 8'h00, 4'hF, 1'b1, 1'b0, 4'h5, 4'h0, 1'b0, 1'b0, 4'h7, 2'd1},
      '{1'b0, 8'hC4, 8'hE1, 8'hC4, 4'hF, 1'b1, 1'b0, 4'h1, 4'h0, 1'b1, 1'b1, 4'h7, 2'd2},
      '{1'b1, 8'h90, 8'h00, 8'h00, 4'hF, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 2'd0},
      '{1'b1, 8'hC4, 8'h01, 8'h78, 4'hF, 1'b1, 1'b0, 4'h1, 4'h7, 1'b0, 1'b0, 4'h0, 2'd2},
      '{1'b0, 8'hC5, 8'h3F, 8'h00, 4'hF, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 2'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_start(input logic [7:0] op, input logic m64, input logic [3:0] mask);
      @(negedge clk);
      start = 1'b1; op_byte = op; mode64 = m64; ext_allow = mask;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b, output int took);
      byte_valid = 1'b1; byte_in = b;
      #1 took = int'(take);
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic chk_fields(input string tag, input vec_t v);
      chk({tag, " R13 is_vec"}, is_vec, v.vec);
      chk({tag, " R5 err"}, err, v.er);
      chk({tag, " R5 map_idx"}, map_idx, v.idx);
      chk({tag, " R6 ext_eff"}, ext_eff, v.ext);
      chk({tag, " R8 vec_l"}, vec_l, v.l);
      chk({tag, " R7 w_bit"}, w_bit, v.w);
      chk({tag, " R8 vreg"}, vreg, v.vr);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int t;
      int nt;
      vec_t zero_v;
      zero_v = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 take", take, 0);
      chk_fields("R1", zero_v);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         do_start(VECS[i].op, VECS[i].m64, VECS[i].mask);
         nt = 0;
         for (int k = 0; k < 3 && !done; k++) begin
            feed(k == 0 ? VECS[i].b1 : VECS[i].b2, t);
            nt += t;
         end
         chk($sformatf("vec%0d R2 done", i), done, 1);
         chk($sformatf("vec%0d R4 R3 bytes taken", i), nt, VECS[i].nt);
         chk_fields($sformatf("vec%0d", i), VECS[i]);
         repeat (3) @(negedge clk);
         chk_fields($sformatf("vec%0d R11 hold", i), VECS[i]);
      end

      // R12: wait while no byte offered
      do_start(8'hC5, 1'b1, 4'hF);
      repeat (3) @(negedge clk);
      chk("R12 busy", busy, 1);
      chk("R12 done", done, 0);
      feed(8'h45, t);
      chk("R12 take", t, 1);
      chk("R12 done", done, 1);
      chk_fields("R12", VECS[1]);

      // R10: end of input awaiting the first byte
      do_start(8'hC4, 1'b1, 4'hF);
      end_of_input = 1'b1;
      #1 chk("R10 take low", take, 0);
      @(negedge clk);
      end_of_input = 1'b0;
      chk("R10 done", done, 1);
      chk("R10 err", err, 1);
      chk("R10 is_vec", is_vec, 0);

      // R10: end of input and second byte in the same cycle
      do_start(8'hC4, 1'b1, 4'hF);
      feed(8'h02, t);
      chk("R10 first byte taken", t, 1);
      end_of_input = 1'b1;
      feed(8'hFD, t);
      end_of_input = 1'b0;
      chk("R10 collide take", t, 0);
      chk("R10 collide err", err, 1);
      chk("R10 collide is_vec", is_vec, 0);
      chk("R10 collide vreg", vreg, 0);

      // R11: restart while awaiting the second byte
      do_start(8'hC4, 1'b1, 4'hF);
      feed(8'hA3, t);
      chk("R11 mid busy", busy, 1);
      do_start(8'hC5, 1'b1, 4'hF);
      feed(8'hF8, t);
      chk("R11 restart done", done, 1);
      chk_fields("R11 restart", VECS[0]);

      // R9 immediate register decode
      mode64 = 1'b1; imm_byte = 8'hB7;
      #1 chk("R9 imm 64", imm_reg, 4'hB);
      mode64 = 1'b0;
      #1 chk("R9 imm narrow", imm_reg, 4'h3);
      imm_byte = 8'h5C;
      #1 chk("R9 imm narrow low", imm_reg, 4'h5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule